// File: doc/BRIEF.md
# Serial Link Reset Sequencer

This block produces the four active-low resets that a high-speed serial converter link needs: a link-domain and a frame-domain reset for the transmit direction, and the same pair for the receive direction. It watches status flags from the clock and transceiver subsystems: PLL lock, transmit ready, receive lock-to-data, receive ready, a transceiver-in-reset indication and a configuration-done flag. From these it decides when each direction may leave reset.

Each output has its own short shift register, clocked by that output's domain clock. While the direction's qualifying condition is false, the whole shift register is cleared at the next rising edge, so assertion is synchronous. Once the condition holds, a one travels through the stages, so release is synchronous too. Transmit and receive are sequenced separately. A parameter per direction lets the frame reset simply follow the link reset, for systems where both domains run at one frequency.

Top module: `serdes_rst_seq`

## Requirements
- R1: While `xcvr_in_rst` is high, all four reset outputs are low (asserted).
- R2: Every change of an output happens only at a rising edge of that output's own clock: `tx_link_clk` for `tx_link_rst_n`, `tx_frame_clk` for `tx_frame_rst_n`, `rx_link_clk` for `rx_link_rst_n`, `rx_frame_clk` for `rx_frame_rst_n`.
- R3: Both transmit outputs stay low unless `pll_locked` and `tx_ready` are both high. When both are high, `cfg_done` is high and `xcvr_in_rst` is low, both transmit outputs go high.
- R4: Both receive outputs stay low unless `cdr_locked` and `rx_ready` are both high. When both are high, `cfg_done` is high and `xcvr_in_rst` is low, both receive outputs go high.
- R5: While `cfg_done` is low, no output goes high.
- R6: An output goes high at the SYNC_STAGES-th rising edge of its own clock (default 2) after its direction's condition becomes true. It goes low at the first rising edge of its own clock after the condition becomes false, including when a status flag drops after release.
- R7: The status of one direction never holds the other direction in reset, and never reasserts it.
- R8: With TX_FRAME_TIED = 1 (or RX_FRAME_TIED = 1), the frame reset of that direction is the same signal as its link reset at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_link_clk | input | 1 | Transmit link-domain clock |
| tx_frame_clk | input | 1 | Transmit frame-domain clock |
| rx_link_clk | input | 1 | Receive link-domain clock |
| rx_frame_clk | input | 1 | Receive frame-domain clock |
| xcvr_in_rst | input | 1 | High while the transceiver is held in reset |
| cfg_done | input | 1 | High once link configuration is complete |
| pll_locked | input | 1 | Transmit PLL lock flag |
| tx_ready | input | 1 | Transmit path ready flag |
| cdr_locked | input | 1 | Receive CDR locked-to-data flag |
| rx_ready | input | 1 | Receive path ready flag |
| tx_link_rst_n | output | 1 | Active-low transmit link reset |
| tx_frame_rst_n | output | 1 | Active-low transmit frame reset |
| rx_link_rst_n | output | 1 | Active-low receive link reset |
| rx_frame_rst_n | output | 1 | Active-low receive frame reset |

## Verification
The only state in this block is the shift registers, so any fault in them shows up as an output edge at the wrong time. That could be a release that comes one edge early or late, or an edge that lines up with the wrong domain's clock. A wrong qualifying term shows within one or two edges of the affected clock: a direction leaves reset with a flag low, or stays in reset with all flags high, or moves when the other direction's flags change. The bench times each release and each reassertion against the exact rising edge where it should occur. It also checks the timestamp of every output transition against the last rising edge of that output's own clock.

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq #(
  parameter int SYNC_STAGES   = 2,
  parameter bit TX_FRAME_TIED = 1'b0,
  parameter bit RX_FRAME_TIED = 1'b0
) (
  input  logic tx_link_clk,
  input  logic tx_frame_clk,
  input  logic rx_link_clk,
  input  logic rx_frame_clk,
  input  logic xcvr_in_rst,
  input  logic cfg_done,
  input  logic pll_locked,
  input  logic tx_ready,
  input  logic cdr_locked,
  input  logic rx_ready,
  output logic tx_link_rst_n,
  output logic tx_frame_rst_n,
  output logic rx_link_rst_n,
  output logic rx_frame_rst_n
);

  localparam int NDOM = 4;

  logic            tx_ok, rx_ok;
  logic [NDOM-1:0] dom_clk, dom_ok, dom_rst_n;

  assign tx_ok = ~xcvr_in_rst & cfg_done & pll_locked & tx_ready;
  assign rx_ok = ~xcvr_in_rst & cfg_done & cdr_locked & rx_ready;

  assign dom_clk = {rx_frame_clk, rx_link_clk, tx_frame_clk, tx_link_clk};
  assign dom_ok  = {rx_ok, rx_ok, tx_ok, tx_ok};

  generate
    for (genvar d = 0; d < NDOM; d++) begin : g_dom
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge dom_clk[d]) begin
        if (!dom_ok[d]) sh <= '0;
        else            sh <= {sh[SYNC_STAGES-2:0], 1'b1};
      end
      assign dom_rst_n[d] = sh[SYNC_STAGES-1];
    end
  endgenerate

  assign tx_link_rst_n  = dom_rst_n[0];
  assign rx_link_rst_n  = dom_rst_n[2];
  assign tx_frame_rst_n = TX_FRAME_TIED ? dom_rst_n[0] : dom_rst_n[1];
  assign rx_frame_rst_n = RX_FRAME_TIED ? dom_rst_n[2] : dom_rst_n[3];

endmodule

// File: rtl/serdes_rst_seq_chk.sv
module serdes_rst_seq_chk (
  input logic tx_link_clk,
  input logic rx_link_clk,
  input logic xcvr_in_rst,
  input logic cfg_done,
  input logic pll_locked,
  input logic tx_ready,
  input logic cdr_locked,
  input logic rx_ready,
  input logic tx_link_rst_n,
  input logic rx_link_rst_n
);

  a_r6_tx_drop: assert property (@(posedge tx_link_clk) disable iff (xcvr_in_rst)
    !(cfg_done && pll_locked && tx_ready) |=> !tx_link_rst_n);

  a_r6_rx_drop: assert property (@(posedge rx_link_clk) disable iff (xcvr_in_rst)
    !(cfg_done && cdr_locked && rx_ready) |=> !rx_link_rst_n);

  a_r3_tx_release_qualified: assert property (@(posedge tx_link_clk) disable iff (xcvr_in_rst)
    $rose(tx_link_rst_n) |-> (pll_locked && tx_ready && $past(pll_locked && tx_ready)));

  a_r4_rx_release_qualified: assert property (@(posedge rx_link_clk) disable iff (xcvr_in_rst)
    $rose(rx_link_rst_n) |-> (cdr_locked && rx_ready && $past(cdr_locked && rx_ready)));

  a_r5_tx_cfg_gate: assert property (@(posedge tx_link_clk) disable iff (xcvr_in_rst)
    $rose(tx_link_rst_n) |-> cfg_done);

  a_r5_rx_cfg_gate: assert property (@(posedge rx_link_clk) disable iff (xcvr_in_rst)
    $rose(rx_link_rst_n) |-> cfg_done);

endmodule

bind serdes_rst_seq serdes_rst_seq_chk u_chk (
  .tx_link_clk   (tx_link_clk),
  .rx_link_clk   (rx_link_clk),
  .xcvr_in_rst   (xcvr_in_rst),
  .cfg_done      (cfg_done),
  .pll_locked    (pll_locked),
  .tx_ready      (tx_ready),
  .cdr_locked    (cdr_locked),
  .rx_ready      (rx_ready),
  .tx_link_rst_n (tx_link_rst_n),
  .rx_link_rst_n (rx_link_rst_n)
);

// File: tb/serdes_rst_seq_tb.sv
`timescale 1ns/1ps
module serdes_rst_seq_tb;

  logic tx_link_clk = 0, tx_frame_clk = 0, rx_link_clk = 0, rx_frame_clk = 0;
  logic xcvr_in_rst = 1, cfg_done = 0, pll_locked = 0, tx_ready = 0, cdr_locked = 0, rx_ready = 0;
  logic txl, txf, rxl, rxf;
  logic t_txl, t_txf, t_rxl, t_rxf;
  int   n_checks = 0, n_errors = 0;
  bit   done = 0;
  time  e_txl = 0, e_txf = 0, e_rxl = 0, e_rxf = 0;

  always #10 tx_link_clk = ~tx_link_clk;
  always #20 tx_frame_clk = ~tx_frame_clk;
  initial begin #5; forever #10 rx_link_clk = ~rx_link_clk; end
  always #15 rx_frame_clk = ~rx_frame_clk;

  serdes_rst_seq u_dut (
    .tx_link_clk(tx_link_clk), .tx_frame_clk(tx_frame_clk),
    .rx_link_clk(rx_link_clk), .rx_frame_clk(rx_frame_clk),
    .xcvr_in_rst(xcvr_in_rst), .cfg_done(cfg_done),
    .pll_locked(pll_locked), .tx_ready(tx_ready),
    .cdr_locked(cdr_locked), .rx_ready(rx_ready),
    .tx_link_rst_n(txl), .tx_frame_rst_n(txf),
    .rx_link_rst_n(rxl), .rx_frame_rst_n(rxf));

  serdes_rst_seq #(.TX_FRAME_TIED(1'b1), .RX_FRAME_TIED(1'b1)) u_dut_tied (
    .tx_link_clk(tx_link_clk), .tx_frame_clk(tx_frame_clk),
    .rx_link_clk(rx_link_clk), .rx_frame_clk(rx_frame_clk),
    .xcvr_in_rst(xcvr_in_rst), .cfg_done(cfg_done),
    .pll_locked(pll_locked), .tx_ready(tx_ready),
    .cdr_locked(cdr_locked), .rx_ready(rx_ready),
    .tx_link_rst_n(t_txl), .tx_frame_rst_n(t_txf),
    .rx_link_rst_n(t_rxl), .rx_frame_rst_n(t_rxf));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req, input logic a, input logic b, input logic c, input logic d);
    check(req, "tx_link_rst_n", txl, a);
    check(req, "tx_frame_rst_n", txf, b);
    check(req, "rx_link_rst_n", rxl, c);
    check(req, "rx_frame_rst_n", rxf, d);
    check("R8", "tied tx frame", t_txf, t_txl);
    check("R8", "tied rx frame", t_rxf, t_rxl);
    check("R8", "tied tx link matches", t_txl, a);
  endtask

  // R2: each output transition must coincide with its own clock edge
  always @(posedge tx_link_clk)  e_txl = $time;
  always @(posedge tx_frame_clk) e_txf = $time;
  always @(posedge rx_link_clk)  e_rxl = $time;
  always @(posedge rx_frame_clk) e_rxf = $time;
  always @(txl) if ($time > 0) check("R2", "tx_link edge aligned",  1'b1, logic'($time == e_txl));
  always @(txf) if ($time > 0) check("R2", "tx_frame edge aligned", 1'b1, logic'($time == e_txf));
  always @(rxl) if ($time > 0) check("R2", "rx_link edge aligned",  1'b1, logic'($time == e_rxl));
  always @(rxf) if ($time > 0) check("R2", "rx_frame edge aligned", 1'b1, logic'($time == e_rxf));

  task automatic t_r1_xcvr_reset;
    cfg_done = 1; pll_locked = 1; tx_ready = 1; cdr_locked = 1; rx_ready = 1;
    #300;
    check_all("R1", 0, 0, 0, 0);
  endtask

  task automatic t_r5_cfg_gate;
    @(negedge tx_link_clk); cfg_done = 0; xcvr_in_rst = 0;
    #300;
    check_all("R5", 0, 0, 0, 0);
  endtask

  task automatic t_r3_tx_qualify;
    @(negedge tx_link_clk); cdr_locked = 0; rx_ready = 0; cfg_done = 1; pll_locked = 1; tx_ready = 0;
    #300; check_all("R3", 0, 0, 0, 0);
    @(negedge tx_link_clk); pll_locked = 0; tx_ready = 1;
    #300; check_all("R3", 0, 0, 0, 0);
    @(negedge tx_link_clk); pll_locked = 1;
    @(posedge tx_link_clk); #1 check("R6", "tx_link low after 1 edge", txl, 1'b0);
    @(posedge tx_link_clk); #1 check("R6", "tx_link high after 2 edges", txl, 1'b1);
    #300; check_all("R3", 1, 1, 0, 0);
  endtask

  task automatic t_r4_rx_qualify;
    @(negedge rx_link_clk); cdr_locked = 1; rx_ready = 0;
    #300; check_all("R4", 1, 1, 0, 0);
    @(negedge rx_link_clk); cdr_locked = 0; rx_ready = 1;
    #300; check_all("R4", 1, 1, 0, 0);
    @(negedge rx_frame_clk); cdr_locked = 1;
    @(posedge rx_frame_clk); #1 check("R6", "rx_frame low after 1 edge", rxf, 1'b0);
    @(posedge rx_frame_clk); #1 check("R6", "rx_frame high after 2 edges", rxf, 1'b1);
    #300; check_all("R4", 1, 1, 1, 1);
  endtask

  task automatic t_r6_loss_of_lock;
    @(negedge tx_link_clk); pll_locked = 0;
    @(posedge tx_link_clk); #1 check("R6", "tx_link reasserted at first edge", txl, 1'b0);
    check("R7", "rx_link unaffected by tx loss", rxl, 1'b1);
    #300; check_all("R6", 0, 0, 1, 1);
    pll_locked = 1; #300; check_all("R6", 1, 1, 1, 1);
    @(negedge rx_link_clk); rx_ready = 0;
    @(posedge rx_link_clk); #1 check("R6", "rx_link reasserted at first edge", rxl, 1'b0);
    check("R7", "tx_link unaffected by rx loss", txl, 1'b1);
    #300; check_all("R7", 1, 1, 0, 0);
    rx_ready = 1; #300; check_all("R7", 1, 1, 1, 1);
    @(negedge tx_link_clk); cfg_done = 0;
    #300; check_all("R5", 0, 0, 0, 0);
    cfg_done = 1; #300; check_all("R5", 1, 1, 1, 1);
  endtask

  task automatic t_r1_reassert;
    @(negedge tx_link_clk); xcvr_in_rst = 1;
    #300; check_all("R1", 0, 0, 0, 0);
  endtask

  initial begin
    #200; check_all("R1", 0, 0, 0, 0);
    t_r1_xcvr_reset;
    t_r5_cfg_gate;
    t_r3_tx_qualify;
    t_r4_rx_qualify;
    t_r6_loss_of_lock;
    t_r1_reassert;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule